// File: doc/BRIEF.md
# Paged Memory Mapper with Bank Strobe Decode

This block lets an 8-bit CPU with a 64 KB address space reach a 512 KB RAM array. The CPU space is cut into four 16 KB pages. Each page has its own page register, and software writes and reads these registers through four consecutive I/O ports. On a memory access, the two top CPU address bits pick one page register. That register supplies five extended address bits, which replace the CPU's top two bits on the RAM side.

The three highest extended bits name one of eight RAM banks. A bank is a pair of 4-bit-wide devices: one holds data bits 0 to 3 and the other holds bits 4 to 7. While the incoming active-low column strobe is asserted, the decoder pulls exactly one of eight active-low bank strobes low. This means a fault seen in one mapper block can be traced to one bank strobe and its device pair.

A read of a mapper port returns the five stored bits in the order they were written, with the three upper bits forced to 1. The block drives the data bus only during such a read. The block contains no state machine: register writes are single-cycle, and all reads and decodes are combinational.

Top module: `page_mapper_top`

## Requirements
- R1: After reset, the page registers for CPU pages 0, 1, 2 and 3 hold 3, 2, 1 and 0.
- R2: When `io_wr` is high at a rising clock edge and `io_addr` is 0xFC + p (p = 0..3), the register for page p takes `io_wdata[4:0]` at that edge. The other page registers keep their values.
- R3: While `io_rd` is high and `io_addr` is 0xFC + p, `io_rdata[4:0]` equals register p in the same bit order as written, with no bit swapped. `io_rdata[7:5]` reads 3'b111.
- R4: `io_rdata_oe` is 1 only while `io_rd` is high and `io_addr` is in 0xFC..0xFF. At all other times `io_rdata_oe` is 0 and `io_rdata` is 0x00.
- R5: `mem_xaddr[4:0]` (MA18..MA14) equals the page register selected by `cpu_page` (the CPU's A15:A14). The value written to a register applies from the cycle after the write.
- R6: While `cas_n` is 1, all eight bits of `bank_cas_n` are 1.
- R7: While `cas_n` is 0, exactly one bit of `bank_cas_n` is 0. Its index equals `mem_xaddr[4:2]`, read with MA18 as the most significant bit and MA16 as the least significant bit.
- R8: A write to a port outside 0xFC..0xFF, and an `io_wr` pulse while `io_rd` is high, change no page register. This is observable through readback and through `mem_xaddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | I/O write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_rdata_oe | output | 1 | Read data output enable |
| cpu_page | input | 2 | CPU address bits A15:A14 |
| cas_n | input | 1 | Incoming active-low column strobe |
| mem_xaddr | output | 5 | Extended address MA18..MA14 |
| bank_cas_n | output | 8 | Active-low one-hot bank strobes |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that `cpu_page` and `io_addr` are held stable around each clock edge. The stability assumption matters for the check that nothing changes without a write, because that check needs the page select to stay still. The bench drives every input at the falling edge, so each input is fixed well before the rising edge. It asserts only one I/O strobe at a time, except in the single R8 case, where it pulses a write during a read and then checks that the register is unchanged.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int DATA_W = 8;

    // Reset image of page register p for a map of n pages: reversed order
    function automatic int unsigned page_reset_value(input int unsigned p,
                                                     input int unsigned n);
        return n - 1 - p;
    endfunction

endpackage

// File: rtl/mapper_page_regs.sv
module mapper_page_regs #(
    parameter int PAGES     = 4,
    parameter int PAGE_BITS = 5,
    localparam int IDX_W    = $clog2(PAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [PAGE_BITS-1:0]  wr_val,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [PAGE_BITS-1:0]  rd_val,
    input  logic [IDX_W-1:0]      map_idx,
    output logic [PAGE_BITS-1:0]  map_val
);
    import mapper_pkg::*;

    logic [PAGE_BITS-1:0] page_q [PAGES];

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        localparam logic [PAGE_BITS-1:0] RST_VAL =
            PAGE_BITS'(page_reset_value(p, PAGES));
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q[p] <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(p))
                page_q[p] <= wr_val;
        end
    end

    always_comb begin
        rd_val  = page_q[rd_idx];
        map_val = page_q[map_idx];
    end

endmodule

// File: rtl/mapper_port_if.sv
module mapper_port_if #(
    parameter int              PAGES     = 4,
    parameter int              PAGE_BITS = 5,
    parameter logic [7:0]      PORT_BASE = 8'hFC,
    localparam int             IDX_W     = $clog2(PAGES),
    localparam int             FILL_W    = mapper_pkg::DATA_W - PAGE_BITS
) (
    input  logic [7:0]            io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      idx,
    output logic [PAGE_BITS-1:0]  wr_val,
    input  logic [PAGE_BITS-1:0]  rd_val,
    output logic [7:0]            io_rdata,
    output logic                  io_rdata_oe
);
    logic hit;
    logic unused_fill;

    // Port block is aligned: top bits match base, low bits pick the page
    assign hit    = (io_addr[7:IDX_W] == PORT_BASE[7:IDX_W]);
    assign idx    = io_addr[IDX_W-1:0];
    assign wr_en  = hit && io_wr && !io_rd;
    assign wr_val = io_wdata[PAGE_BITS-1:0];
    assign unused_fill = ^io_wdata[7:PAGE_BITS];

    always_comb begin
        if (hit && io_rd) begin
            io_rdata_oe = 1'b1;
            io_rdata    = {{FILL_W{1'b1}}, rd_val};
        end else begin
            io_rdata_oe = 1'b0;
            io_rdata    = '0;
        end
    end

endmodule

// File: rtl/mapper_bank_dec.sv
module mapper_bank_dec #(
    parameter int  SEL_W = 3,
    localparam int BANKS = 1 << SEL_W
) (
    input  logic             cas_n,
    input  logic [SEL_W-1:0] sel,
    output logic [BANKS-1:0] bank_cas_n
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_cas_n[b] = !(!cas_n && sel == SEL_W'(b));
    end

endmodule

// File: rtl/page_mapper_top.sv
module page_mapper_top #(
    parameter int         PAGES     = 4,
    parameter int         PAGE_BITS = 5,
    parameter int         SEL_W     = 3,
    parameter logic [7:0] PORT_BASE = 8'hFC,
    localparam int        IDX_W     = $clog2(PAGES),
    localparam int        BANKS     = 1 << SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 io_rdata_oe,
    input  logic [IDX_W-1:0]     cpu_page,
    input  logic                 cas_n,
    output logic [PAGE_BITS-1:0] mem_xaddr,
    output logic [BANKS-1:0]     bank_cas_n
);
    logic                 wr_en;
    logic [IDX_W-1:0]     port_idx;
    logic [PAGE_BITS-1:0] wr_val;
    logic [PAGE_BITS-1:0] rd_val;

    mapper_port_if #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS), .PORT_BASE(PORT_BASE)) u_port (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .wr_en(wr_en), .idx(port_idx), .wr_val(wr_val), .rd_val(rd_val),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
    );

    mapper_page_regs #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(port_idx),
        .wr_val(wr_val), .rd_idx(port_idx), .rd_val(rd_val),
        .map_idx(cpu_page), .map_val(mem_xaddr)
    );

    mapper_bank_dec #(.SEL_W(SEL_W)) u_dec (
        .cas_n(cas_n),
        .sel(mem_xaddr[PAGE_BITS-1 -: SEL_W]),
        .bank_cas_n(bank_cas_n)
    );

endmodule

// File: rtl/page_mapper_checker.sv
module page_mapper_checker #(
    parameter int         PAGE_BITS = 5,
    parameter int         SEL_W     = 3,
    parameter logic [7:0] PORT_BASE = 8'hFC
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  io_rdata_oe,
    input logic [1:0]            cpu_page,
    input logic                  cas_n,
    input logic [PAGE_BITS-1:0]  mem_xaddr,
    input logic [(1<<SEL_W)-1:0] bank_cas_n
);
    logic port_hit;
    assign port_hit = (io_addr[7:2] == PORT_BASE[7:2]);

    assert_wr_maps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_rd && port_hit) |=>
        (cpu_page != $past(io_addr[1:0]) || mem_xaddr == $past(io_wdata[PAGE_BITS-1:0])));

    assert_fill_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> io_rdata[7:PAGE_BITS] == '1);

    assert_oe_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && port_hit) |-> (!io_rdata_oe && io_rdata == 8'h00));

    assert_idle_all_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |-> (&bank_cas_n));

    assert_one_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> ($countones(~bank_cas_n) == 1 &&
                    !bank_cas_n[mem_xaddr[PAGE_BITS-1 -: SEL_W]]));

    assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && !io_rd && port_hit) |=>
        (!$stable(cpu_page) || $stable(mem_xaddr)));

endmodule

bind page_mapper_top page_mapper_checker #(
    .PAGE_BITS(PAGE_BITS), .SEL_W(SEL_W), .PORT_BASE(PORT_BASE)
) u_checker (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .cpu_page(cpu_page), .cas_n(cas_n), .mem_xaddr(mem_xaddr),
    .bank_cas_n(bank_cas_n)
);

// File: tb/tb_page_mapper_top.sv
module tb_page_mapper_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       io_rdata_oe;
    logic [1:0] cpu_page = 2'd0;
    logic       cas_n = 1'b1;
    logic [4:0] mem_xaddr;
    logic [7:0] bank_cas_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_mapper_top dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .cpu_page(cpu_page), .cas_n(cas_n), .mem_xaddr(mem_xaddr),
        .bank_cas_n(bank_cas_n)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a[7:2] == 6'h3F) model[a[1:0]] = d[4:0];
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; oe = io_rdata_oe;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        for (int p = 0; p < 4; p++) begin
            io_read(8'hFC + 8'(p), d, oe);
            check("R1", "reset readback", d, {3'b111, 5'(3 - p)});
            check("R4", "oe on mapper read", {7'd0, oe}, 8'd1);
            cpu_page = 2'(p); #1;
            check("R1", "reset xaddr", {3'd0, mem_xaddr}, {3'd0, 5'(3 - p)});
        end
    endtask

    task automatic t_write_readback();
        logic [7:0] d; logic oe;
        logic [7:0] pats [5] = '{8'h10, 8'h08, 8'h1F, 8'h00, 8'hE5};
        foreach (pats[i]) begin
            io_write(8'hFD, pats[i]);
            io_read(8'hFD, d, oe);
            check("R3", "readback order", d, {3'b111, pats[i][4:0]});
            for (int p = 0; p < 4; p++) begin
                io_read(8'hFC + 8'(p), d, oe);
                check("R2", "per-page value", d, {3'b111, model[p]});
            end
        end
    endtask

    task automatic t_page_select();
        io_write(8'hFC, 8'h05);
        io_write(8'hFD, 8'h0A);
        io_write(8'hFE, 8'h13);
        io_write(8'hFF, 8'h1C);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); cpu_page = 2'(p); #1;
            check("R5", "xaddr from page", {3'd0, mem_xaddr}, {3'd0, model[p]});
        end
        // new value seen the cycle after the write edge
        @(negedge clk); cpu_page = 2'd2;
        io_addr = 8'hFE; io_wdata = 8'h07; io_wr = 1'b1;
        #1;
        check("R5", "old value before edge", {3'd0, mem_xaddr}, {3'd0, model[2]});
        @(negedge clk); io_wr = 1'b0; model[2] = 5'h07; #1;
        check("R5", "new value after edge", {3'd0, mem_xaddr}, 8'h07);
    endtask

    task automatic t_bank_decode();
        for (int b = 0; b < 8; b++) begin
            io_write(8'hFC, {3'd0, 3'(b), 2'b10});
            @(negedge clk); cpu_page = 2'd0; cas_n = 1'b1; #1;
            check("R6", "idle strobes", bank_cas_n, 8'hFF);
            cas_n = 1'b0; #1;
            check("R7", "one-hot bank", bank_cas_n, ~(8'h01 << b));
            @(negedge clk); cas_n = 1'b1;
        end
    endtask

    task automatic t_ignored();
        logic [7:0] d; logic oe;
        @(negedge clk); io_addr = 8'hFD; io_rd = 1'b0; #1;
        check("R4", "no read no oe", {7'd0, io_rdata_oe}, 8'd0);
        check("R4", "no read zero bus", io_rdata, 8'h00);
        io_read(8'hFB, d, oe);
        check("R4", "foreign port oe", {7'd0, oe}, 8'd0);
        check("R4", "foreign port data", d, 8'h00);
        io_write(8'hFB, 8'h1E);
        io_write(8'h7C, 8'h1E);
        for (int p = 0; p < 4; p++) begin
            io_read(8'hFC + 8'(p), d, oe);
            check("R8", "foreign write ignored", d, {3'b111, model[p]});
        end
        // write pulse during a read
        @(negedge clk); io_addr = 8'hFF; io_wdata = 8'h11; io_rd = 1'b1; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
        cpu_page = 2'd3; #1;
        check("R8", "write during read ignored", {3'd0, mem_xaddr}, {3'd0, model[3]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++) model[p] = 5'(3 - p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_readback();
        t_page_select();
        t_bank_decode();
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule